// File: doc/BRIEF.md
# Stack Pop Address Sequencer

This block carries out the stack side of a pop for a segmented processor core. When a request arrives, it works out the operand size and the stack-pointer width from the mode and segment flags. It reads the old top of stack through a request/acknowledge port. It then writes the advanced stack pointer, and after that it delivers the popped value to the selected destination. A destination can be a general register, the stack pointer, the stack-segment register, or a memory location. The memory address may use the already-advanced stack pointer as its base.

A pop into the stack-segment register raises an interrupt shadow. The core uses this shadow to hold off maskable and non-maskable interrupts until the next instruction retires. The shadow is not re-armed by a stack-segment pop that lands while it is already active. Descriptor loading, instruction decode and the memory itself sit outside the block.

Top module: `stack_pop_seq`

## Requirements
- R1: Operand size comes from `opsize_code_i`. Code 0 selects the default size, code 1 selects 16 bits, code 2 selects 32 bits and code 3 selects 64 bits. The default size is 64 bits in 64-bit mode; outside it, the default is 32 bits when `cs_big_i` is set and 16 bits when it is clear. `rd_size_o` reports the size as 0, 1 or 2 for 16, 32 or 64 bits. The pointer advances by 2, 4 or 8 bytes to match.
- R2: The pointer width is 64 bits in 64-bit mode. Outside 64-bit mode it is 32 bits when `ss_big_i` is set and 16 bits when it is clear. `rd_addr_o` is the stack pointer cut to that width and zero-extended.
- R3: The increment wraps modulo 2^width of the pointer width. Stack-pointer bits above that width pass through to `sp_wdata_o` unchanged.
- R4: Code 2 in 64-bit mode and code 3 outside it are invalid. Either one gives a one-cycle `err_o` one clock after the request. It produces no read, no pointer write and no destination write.
- R5: `rd_req_o` rises one clock after an accepted request. It stays high with a stable `rd_addr_o` until the cycle in which `rd_ack_i` is high.
- R6: The pointer write (`sp_we_o`) comes one clock after the acknowledge. The destination write (`dst_we_o`, together with `done_o`) follows one clock later. The two never occur in the same cycle.
- R7: For a memory destination (`dst_sel_i` = 3), `dst_addr_o` is formed at the pointer width and zero-extended. When `mem_base_sp_i` is set, the address is the advanced stack pointer plus `mem_disp_i`. Otherwise it is `mem_base_i` plus `mem_disp_i`.
- R8: When the destination is the stack pointer (`dst_sel_i` = 1), the advanced pointer is written first. The popped value then overwrites it through the destination write.
- R9: `dst_wdata_o` is the read data zero-extended from the operand size.
- R10: Completion of a pop with `dst_sel_i` = 2 (stack segment) sets `irq_shadow_o` from the next clock. The shadow clears on the next instruction retirement, which is either a `retire_i` pulse or the completion of another pop.
- R11: A stack-segment pop that completes while `irq_shadow_o` is high clears the shadow and does not re-arm it.
- R12: After reset all strobes, `busy_o` and `irq_shadow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pop request, sampled while idle |
| sp_i | input | 64 | Current stack pointer |
| mode64_i | input | 1 | 64-bit mode |
| cs_big_i | input | 1 | Code-segment default size flag (32-bit when set) |
| ss_big_i | input | 1 | Stack-segment pointer width flag (32-bit when set) |
| opsize_code_i | input | 2 | Operand size request code |
| dst_sel_i | input | 2 | Destination: 0 register, 1 stack pointer, 2 stack segment, 3 memory |
| mem_base_sp_i | input | 1 | Memory destination uses the stack pointer as base |
| mem_base_i | input | 64 | Memory destination base when not the stack pointer |
| mem_disp_i | input | 64 | Memory destination displacement |
| rd_ack_i | input | 1 | Stack read acknowledge |
| rd_data_i | input | 64 | Stack read data |
| retire_i | input | 1 | Pulse per instruction retired elsewhere |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Invalid request strobe |
| rd_req_o | output | 1 | Stack read request |
| rd_addr_o | output | 64 | Stack read address |
| rd_size_o | output | 2 | Stack read size code |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 64 | Advanced stack pointer |
| dst_we_o | output | 1 | Destination write strobe |
| dst_sel_o | output | 2 | Destination of the write |
| dst_addr_o | output | 64 | Memory destination address |
| dst_wdata_o | output | 64 | Popped value |
| done_o | output | 1 | Pop completion strobe |
| irq_shadow_o | output | 1 | Interrupt hold-off |

## Verification
Pops are run with each pointer width crossed against different operand sizes. Each pointer sits just below a wrap boundary, so an increment or wrap at the wrong width shows up as a wrong upper half. Read data carries nonzero high bytes, which tells a correct zero-extension apart from a pass-through. Memory destinations are driven once with a stack-pointer base and once with a plain base, which separates pre- and post-increment addressing. Runs of one, two and three stack-segment pops, and a retire pulse, separate a correct shadow from one that re-arms or stays stuck.

// File: rtl/stack_pop_pkg.sv
package stack_pop_pkg;
  localparam int unsigned SP_W = 64;

  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2} size_e;
  typedef enum logic [1:0] {DST_GPR = 2'd0, DST_SP = 2'd1, DST_SS = 2'd2, DST_MEM = 2'd3} dst_e;
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_INCR, ST_DEST, ST_ERR} state_e;

  function automatic logic [SP_W-1:0] width_mask(input size_e s);
    case (s)
      SZ16:    return {{(SP_W-16){1'b0}}, 16'hFFFF};
      SZ32:    return {{(SP_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: return '1;
    endcase
  endfunction

  function automatic logic [SP_W-1:0] size_bytes(input size_e s);
    case (s)
      SZ16:    return SP_W'(2);
      SZ32:    return SP_W'(4);
      default: return SP_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/pop_size_dec.sv
module pop_size_dec
  import stack_pop_pkg::*;
(
  input  logic       mode64_i,
  input  logic       cs_big_i,
  input  logic       ss_big_i,
  input  logic [1:0] code_i,
  output size_e      op_size_o,
  output size_e      ptr_size_o,
  output logic       invalid_o
);
  always_comb begin
    case (code_i)
      2'd0:    op_size_o = mode64_i ? SZ64 : (cs_big_i ? SZ32 : SZ16);
      2'd1:    op_size_o = SZ16;
      2'd2:    op_size_o = SZ32;
      default: op_size_o = SZ64;
    endcase
    ptr_size_o = mode64_i ? SZ64 : (ss_big_i ? SZ32 : SZ16);
    // 32-bit pops are not encodable in 64-bit mode; 64-bit pops need it
    invalid_o  = (mode64_i && code_i == 2'd2) || (!mode64_i && code_i == 2'd3);
  end
endmodule

// File: rtl/pop_ptr_math.sv
module pop_ptr_math
  import stack_pop_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  input  size_e           op_size_i,
  input  size_e           ptr_size_i,
  input  logic            base_sp_i,
  input  logic [SP_W-1:0] mem_base_i,
  input  logic [SP_W-1:0] mem_disp_i,
  output logic [SP_W-1:0] rd_addr_o,
  output logic [SP_W-1:0] new_sp_o,
  output logic [SP_W-1:0] dst_addr_o
);
  localparam int NW = 3;

  logic [SP_W-1:0] inc;
  logic [SP_W-1:0] rd_w   [NW];
  logic [SP_W-1:0] sp_w   [NW];
  logic [SP_W-1:0] addr_w [NW];

  assign inc = size_bytes(op_size_i);

  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam size_e           WS = size_e'(g);
    localparam logic [SP_W-1:0] M  = width_mask(WS);
    logic [SP_W-1:0] sum_sp;
    logic [SP_W-1:0] base;
    assign sum_sp    = sp_i + inc;
    assign sp_w[g]   = (sp_i & ~M) | (sum_sp & M);
    assign rd_w[g]   = sp_i & M;
    // effective address uses the already-advanced pointer
    assign base      = base_sp_i ? sp_w[g] : mem_base_i;
    assign addr_w[g] = (base + mem_disp_i) & M;
  end

  always_comb begin
    case (ptr_size_i)
      SZ16:    begin rd_addr_o = rd_w[0]; new_sp_o = sp_w[0]; dst_addr_o = addr_w[0]; end
      SZ32:    begin rd_addr_o = rd_w[1]; new_sp_o = sp_w[1]; dst_addr_o = addr_w[1]; end
      default: begin rd_addr_o = rd_w[2]; new_sp_o = sp_w[2]; dst_addr_o = addr_w[2]; end
    endcase
  end

  always_comb begin
    if (ptr_size_i == SZ16)
      AST_WRAP16_HI_KEPT: assert ((new_sp_o >> 16) == (sp_i >> 16)); // R3
    if (ptr_size_i == SZ32)
      AST_WRAP32_HI_KEPT: assert ((new_sp_o >> 32) == (sp_i >> 32)); // R3
  end
endmodule

// File: rtl/pop_seq_fsm.sv
module pop_seq_fsm
  import stack_pop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            invalid_i,
  input  size_e           op_size_i,
  input  size_e           ptr_size_i,
  input  logic [SP_W-1:0] sp_i,
  input  dst_e            dst_i,
  input  logic            base_sp_i,
  input  logic [SP_W-1:0] mem_base_i,
  input  logic [SP_W-1:0] mem_disp_i,
  input  logic            rd_ack_i,
  input  logic [SP_W-1:0] rd_data_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            rd_req_o,
  output logic            sp_we_o,
  output logic            dst_we_o,
  output size_e           op_size_o,
  output size_e           ptr_size_o,
  output logic [SP_W-1:0] sp_o,
  output dst_e            dst_o,
  output logic            base_sp_o,
  output logic [SP_W-1:0] mem_base_o,
  output logic [SP_W-1:0] mem_disp_o,
  output logic [SP_W-1:0] data_o
);
  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_size_o  <= SZ16;
      ptr_size_o <= SZ16;
      sp_o       <= '0;
      dst_o      <= DST_GPR;
      base_sp_o  <= 1'b0;
      mem_base_o <= '0;
      mem_disp_o <= '0;
      data_o     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (invalid_i) state_q <= ST_ERR;
          else begin
            state_q    <= ST_READ;
            op_size_o  <= op_size_i;
            ptr_size_o <= ptr_size_i;
            sp_o       <= sp_i;
            dst_o      <= dst_i;
            base_sp_o  <= base_sp_i;
            mem_base_o <= mem_base_i;
            mem_disp_o <= mem_disp_i;
          end
        end
        ST_READ: if (rd_ack_i) begin
          data_o  <= rd_data_i & width_mask(op_size_o);
          state_q <= ST_INCR;
        end
        ST_INCR: state_q <= ST_DEST;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign err_o    = state_q == ST_ERR;
  assign rd_req_o = state_q == ST_READ;
  assign sp_we_o  = state_q == ST_INCR;
  assign dst_we_o = state_q == ST_DEST;

  AST_SP_BEFORE_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> $past(sp_we_o)); // R6
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, sp_we_o, dst_we_o, err_o})); // R6
  AST_ERR_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !rd_req_o && !sp_we_o); // R4
  AST_ACK_TO_SPWE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_ack_i |=> sp_we_o); // R6
endmodule

// File: rtl/pop_irq_shadow.sv
module pop_irq_shadow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic ss_load_i,
  input  logic retire_i,
  output logic shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      shadow_o <= 1'b0;
    else if (done_i && ss_load_i && !shadow_o) shadow_o <= 1'b1;
    else if (done_i || retire_i)      shadow_o <= 1'b0;  // a stacked stack-segment pop does not re-arm
  end

  AST_SHADOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && ss_load_i && !shadow_o |=> shadow_o); // R10
  AST_SHADOW_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_o && (done_i || retire_i) |=> !shadow_o); // R11
endmodule

// File: rtl/stack_pop_seq.sv
module stack_pop_seq
  import stack_pop_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic            mode64_i,
  input  logic            cs_big_i,
  input  logic            ss_big_i,
  input  logic [1:0]      opsize_code_i,
  input  logic [1:0]      dst_sel_i,
  input  logic            mem_base_sp_i,
  input  logic [SP_W-1:0] mem_base_i,
  input  logic [SP_W-1:0] mem_disp_i,
  input  logic            rd_ack_i,
  input  logic [SP_W-1:0] rd_data_i,
  input  logic            retire_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            rd_req_o,
  output logic [SP_W-1:0] rd_addr_o,
  output logic [1:0]      rd_size_o,
  output logic            sp_we_o,
  output logic [SP_W-1:0] sp_wdata_o,
  output logic            dst_we_o,
  output logic [1:0]      dst_sel_o,
  output logic [SP_W-1:0] dst_addr_o,
  output logic [SP_W-1:0] dst_wdata_o,
  output logic            done_o,
  output logic            irq_shadow_o
);
  size_e           req_op, req_ptr, ctx_op, ctx_ptr;
  logic            req_bad, ctx_base_sp;
  dst_e            ctx_dst;
  logic [SP_W-1:0] ctx_sp, ctx_base, ctx_disp;

  pop_size_dec u_dec (
    .mode64_i  (mode64_i),
    .cs_big_i  (cs_big_i),
    .ss_big_i  (ss_big_i),
    .code_i    (opsize_code_i),
    .op_size_o (req_op),
    .ptr_size_o(req_ptr),
    .invalid_o (req_bad)
  );

  pop_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .invalid_i (req_bad),
    .op_size_i (req_op),
    .ptr_size_i(req_ptr),
    .sp_i      (sp_i),
    .dst_i     (dst_e'(dst_sel_i)),
    .base_sp_i (mem_base_sp_i),
    .mem_base_i(mem_base_i),
    .mem_disp_i(mem_disp_i),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .busy_o    (busy_o),
    .err_o     (err_o),
    .rd_req_o  (rd_req_o),
    .sp_we_o   (sp_we_o),
    .dst_we_o  (dst_we_o),
    .op_size_o (ctx_op),
    .ptr_size_o(ctx_ptr),
    .sp_o      (ctx_sp),
    .dst_o     (ctx_dst),
    .base_sp_o (ctx_base_sp),
    .mem_base_o(ctx_base),
    .mem_disp_o(ctx_disp),
    .data_o    (dst_wdata_o)
  );

  pop_ptr_math u_math (
    .sp_i      (ctx_sp),
    .op_size_i (ctx_op),
    .ptr_size_i(ctx_ptr),
    .base_sp_i (ctx_base_sp),
    .mem_base_i(ctx_base),
    .mem_disp_i(ctx_disp),
    .rd_addr_o (rd_addr_o),
    .new_sp_o  (sp_wdata_o),
    .dst_addr_o(dst_addr_o)
  );

  pop_irq_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done_o),
    .ss_load_i(ctx_dst == DST_SS),
    .retire_i (retire_i),
    .shadow_o (irq_shadow_o)
  );

  assign rd_size_o = ctx_op;
  assign dst_sel_o = ctx_dst;
  assign done_o    = dst_we_o;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R5
  AST_SP_STABLE_TO_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |=> dst_we_o && $stable(dst_addr_o)); // R7
endmodule

// File: tb/stack_pop_seq_test.sv
module stack_pop_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode64 = 1'b0, cs_big = 1'b0, ss_big = 1'b0;
  logic [63:0] sp = '0, mbase = '0, mdisp = '0, rdata = '0;
  logic [1:0]  code = '0, dsel = '0;
  logic        bsp = 1'b0, ack = 1'b0, retire = 1'b0;
  logic        busy, err, rreq, spwe, dwe, done, shadow;
  logic [63:0] raddr, spwd, daddr, dwd;
  logic [1:0]  rsize, dso;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  stack_pop_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sp_i(sp), .mode64_i(mode64),
    .cs_big_i(cs_big), .ss_big_i(ss_big), .opsize_code_i(code), .dst_sel_i(dsel),
    .mem_base_sp_i(bsp), .mem_base_i(mbase), .mem_disp_i(mdisp), .rd_ack_i(ack),
    .rd_data_i(rdata), .retire_i(retire), .busy_o(busy), .err_o(err), .rd_req_o(rreq),
    .rd_addr_o(raddr), .rd_size_o(rsize), .sp_we_o(spwe), .sp_wdata_o(spwd),
    .dst_we_o(dwe), .dst_sel_o(dso), .dst_addr_o(daddr), .dst_wdata_o(dwd),
    .done_o(done), .irq_shadow_o(shadow)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_pop(input logic m64, input logic csb, input logic ssb, input logic [1:0] cd,
                        input logic [1:0] ds, input logic bs, input logic [63:0] s,
                        input logic [63:0] base, input logic [63:0] disp, input logic [63:0] data,
                        input int waitc, input logic [63:0] e_rd, input logic [1:0] e_sz,
                        input logic [63:0] e_sp, input logic [63:0] e_wd, input logic [63:0] e_da);
    @(negedge clk);
    mode64 = m64; cs_big = csb; ss_big = ssb; code = cd; dsel = ds; bsp = bs;
    sp = s; mbase = base; mdisp = disp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({63'd0, rreq}, 64'd1, "R5 rd_req");
    chk(raddr, e_rd, "R2 rd_addr");
    chk({62'd0, rsize}, {62'd0, e_sz}, "R1 rd_size");
    for (int i = 0; i < waitc; i++) begin
      @(negedge clk);
      chk({63'd0, rreq}, 64'd1, "R5 rd_req held");
      chk(raddr, e_rd, "R5 rd_addr stable");
    end
    ack = 1'b1; rdata = data;
    @(negedge clk);
    ack = 1'b0; rdata = '0;
    chk({62'd0, spwe, dwe}, 64'd2, "R6 sp write alone");
    chk(spwd, e_sp, "R3 sp_wdata");
    @(negedge clk);
    chk({62'd0, dwe, done}, 64'd3, "R6 dst write after sp");
    chk({62'd0, dso}, {62'd0, ds}, "R8 dst_sel");
    chk(dwd, e_wd, "R9 dst_wdata");
    if (ds == 2'd3) chk(daddr, e_da, "R7 dst_addr");
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk({57'd0, busy, err, rreq, spwe, dwe, done, shadow}, 64'd0, "R12 reset outputs");
  endtask

  task automatic t_sizes;
    // R1 default 32 / R2 ptr32
    do_pop(0, 1, 1, 2'd0, 2'd0, 0, 64'h1000, 0, 0, 64'hDEAD_BEEF_CAFE_F00D, 0,
           64'h1000, 2'd1, 64'h1004, 64'h0000_0000_CAFE_F00D, 0);
    // R3 16-bit wrap keeps upper bits, R9 zero-extend 16
    do_pop(0, 1, 0, 2'd1, 2'd0, 0, 64'hABCD_FFFE, 0, 0, 64'hFFFF_FFFF_FFFF_1234, 0,
           64'hFFFE, 2'd0, 64'hABCD_0000, 64'h1234, 0);
    // R1 64-bit default in long mode
    do_pop(1, 0, 0, 2'd0, 2'd0, 0, 64'h7FFF_FFFF_FFFF_FFF8, 0, 0, 64'h1122_3344_5566_7788, 0,
           64'h7FFF_FFFF_FFFF_FFF8, 2'd2, 64'h8000_0000_0000_0000, 64'h1122_3344_5566_7788, 0);
    // R3 32-bit wrap with 16-bit default op, R5 delayed ack
    do_pop(0, 0, 1, 2'd0, 2'd0, 0, 64'h1_FFFF_FFFE, 0, 0, 64'hAAAA_5555, 3,
           64'hFFFF_FFFE, 2'd0, 64'h1_0000_0000, 64'h5555, 0);
    // R1 explicit 32 and explicit 64
    do_pop(0, 0, 1, 2'd2, 2'd0, 0, 64'h200, 0, 0, 64'h1_2345_6789, 0,
           64'h200, 2'd1, 64'h204, 64'h2345_6789, 0);
    do_pop(1, 0, 0, 2'd3, 2'd0, 0, 64'h100, 0, 0, 64'h42, 0,
           64'h100, 2'd2, 64'h108, 64'h42, 0);
  endtask

  task automatic t_mem_dest;
    // R7 sp base: advanced pointer wraps to 0, address = 0x10
    do_pop(0, 1, 0, 2'd0, 2'd3, 1, 64'hFFFC, 64'h9999, 64'h10, 64'h77, 0,
           64'hFFFC, 2'd1, 64'h0, 64'h77, 64'h10);
    // R7 plain base
    do_pop(0, 1, 1, 2'd0, 2'd3, 0, 64'h300, 64'h5000, 64'h20, 64'h88, 0,
           64'h300, 2'd1, 64'h304, 64'h88, 64'h5020);
  endtask

  task automatic t_dest_sp;
    // R8 pointer advanced first, then overwritten by popped value
    do_pop(1, 0, 0, 2'd0, 2'd1, 0, 64'h40, 0, 0, 64'h9000, 0,
           64'h40, 2'd2, 64'h48, 64'h9000, 0);
  endtask

  task automatic t_invalid;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      mode64 = (k == 0); code = (k == 0) ? 2'd2 : 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({62'd0, err, rreq}, 64'd2, "R4 err strobe no read");
      @(negedge clk);
      chk({60'd0, err, rreq, spwe, dwe}, 64'd0, "R4 no activity after err");
      chk({63'd0, busy}, 64'd0, "R4 idle after err");
    end
  endtask

  task automatic ss_pop;
    do_pop(0, 1, 1, 2'd0, 2'd2, 0, 64'h800, 0, 0, 64'h10, 0,
           64'h800, 2'd1, 64'h804, 64'h10, 0);
  endtask

  task automatic t_shadow;
    ss_pop();
    chk({63'd0, shadow}, 64'd1, "R10 shadow set");
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    chk({63'd0, shadow}, 64'd0, "R10 shadow cleared by retire");
    ss_pop();
    chk({63'd0, shadow}, 64'd1, "R10 first of run sets");
    ss_pop();
    chk({63'd0, shadow}, 64'd0, "R11 second of run no rearm");
    ss_pop();
    chk({63'd0, shadow}, 64'd1, "R11 third arms again");
    do_pop(0, 1, 1, 2'd0, 2'd0, 0, 64'h900, 0, 0, 64'h1, 0,
           64'h900, 2'd1, 64'h904, 64'h1, 0);
    chk({63'd0, shadow}, 64'd0, "R10 cleared by next pop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_mem_dest();
    t_dest_sp();
    t_invalid();
    t_shadow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule